// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches a vector of already synchronised pin levels and turns them into interrupt requests. Each line is given its own trigger condition by three configuration bits: a trigger class, a polarity and a dual-edge select. The class picks edge or level triggering. The polarity picks the rising or the falling edge in edge class, and active-high or active-low in level class. The dual-edge select makes either transition count in edge class, whatever the polarity says.

Edge events are held in a sticky raw status vector until software clears them by writing ones to a clear register. Level-class status simply follows the qualified pin level. A per-line enable decides whether a line may raise status at all. A separate per-line mask hides raw status from the masked view and from the interrupt output. The single interrupt output is the registered OR of all masked status bits.

Configuration, status and clear registers sit on a plain register bus: one cycle write strobe, combinational read data selected by address.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration register reads 0, the raw and masked status read 0 and `irq_out` is 0.
- R2: Register offsets are: enable 0x20, raw status 0x24 (read-only), masked status 0x28 (read-only), mask 0x2C, clear 0x30 (write-only, reads 0), trigger class 0x34, dual-edge 0x38, polarity 0x3C. Bit n of each register belongs to line n, and configuration registers read back what was written.
- R3: A line with class 0, dual-edge 0 and polarity 0 latches raw status on a 0-to-1 pin transition, and not on a 1-to-0 transition. The raw bit reads 1 from the first clock edge after the pin changes.
- R4: A line with class 0, dual-edge 0 and polarity 1 latches raw status on a 1-to-0 transition, and not on a 0-to-1 transition.
- R5: A line with class 0 and dual-edge 1 latches raw status on either transition, whatever its polarity bit holds.
- R6: A line with class 1 shows raw status equal to the pin level when polarity is 0, and equal to the inverted pin level when polarity is 1.
- R7: Latched edge status stays set after the pin returns to its idle level. It clears only when 1 is written to its bit of the clear register; writing 0 to that bit leaves it set.
- R8: Writing 1 to the clear register does not remove level-class status while the qualified level stays active.
- R9: A line whose enable bit is 0 raises no status, whatever its pin does.
- R10: Masked status equals raw status AND NOT mask. `irq_out` equals the OR of masked status one clock later.
- R11: When a qualifying edge and a clear write reach the same line in the same cycle, the line's raw status is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | NUM_LINES | Register write data |
| reg_rdata | output | NUM_LINES | Read data for `reg_addr`, combinational |
| pin_level | input | NUM_LINES | Synchronised pin levels |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
A vector table drives each of the five trigger settings with both a qualifying and a non-qualifying pin transition on different lines. This shows that the polarity and dual-edge bits choose the right transition, and that the level class follows the pin instead of latching it. Directed sequences then set apart the sticky edge status, the clear register, a line held active in level class, a disabled line, and the masked view against the raw view. A final sequence puts a pin edge and a clear write in the same cycle to show that the event takes priority.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_CLASS  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_DUAL   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h3C;
endpackage

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] class_q,
  output logic [NUM_LINES-1:0] dual_q,
  output logic [NUM_LINES-1:0] pol_q,
  output logic [NUM_LINES-1:0] clr_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      class_q <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      case (addr)
        OFF_ENABLE: en_q    <= wdata;
        OFF_MASK:   mask_q  <= wdata;
        OFF_CLASS:  class_q <= wdata;
        OFF_DUAL:   dual_q  <= wdata;
        OFF_POL:    pol_q   <= wdata;
        default: ;
      endcase
    end
  end

  // Clear register holds no state: a write produces a one-cycle pulse vector.
  assign clr_vec = (wr && addr == OFF_CLEAR) ? wdata : '0;
endmodule

// File: rtl/gpio_irq_line_bank.sv
module gpio_irq_line_bank #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin,
  input  logic [NUM_LINES-1:0] en,
  input  logic [NUM_LINES-1:0] lvl_class,
  input  logic [NUM_LINES-1:0] dual,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] raw
);
  logic [NUM_LINES-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic rise, fall, edge_hit, lvl_act, latched;

    assign rise     = pin[g] & ~pin_q[g];
    assign fall     = ~pin[g] & pin_q[g];
    assign edge_hit = en[g] & ~lvl_class[g] &
                      (dual[g] ? (rise | fall) : (pol[g] ? fall : rise));
    assign lvl_act  = en[g] & lvl_class[g] & (pin[g] ^ pol[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            latched <= 1'b0;
      else if (lvl_class[g]) latched <= 1'b0;
      else if (edge_hit)     latched <= 1'b1;   // new event beats a clear
      else if (clr[g])       latched <= 1'b0;
    end

    assign raw[g] = lvl_class[g] ? lvl_act : latched;
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] raw,
  input  logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] masked,
  output logic                 irq
);
  assign masked = raw & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic [NUM_LINES-1:0] pin_level,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] en_q, mask_q, class_q, dual_q, pol_q, clr_vec;
  logic [NUM_LINES-1:0] raw_stat, masked_stat;

  gpio_irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .mask_q(mask_q), .class_q(class_q), .dual_q(dual_q),
    .pol_q(pol_q), .clr_vec(clr_vec)
  );

  gpio_irq_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk(clk), .rst_n(rst_n), .pin(pin_level), .en(en_q), .lvl_class(class_q),
    .dual(dual_q), .pol(pol_q), .clr(clr_vec), .raw(raw_stat)
  );

  gpio_irq_merge #(.NUM_LINES(NUM_LINES)) u_merge (
    .clk(clk), .rst_n(rst_n), .raw(raw_stat), .mask(mask_q),
    .masked(masked_stat), .irq(irq_out)
  );

  always_comb begin
    case (reg_addr)
      OFF_ENABLE: reg_rdata = en_q;
      OFF_RAW:    reg_rdata = raw_stat;
      OFF_MASKED: reg_rdata = masked_stat;
      OFF_MASK:   reg_rdata = mask_q;
      OFF_CLASS:  reg_rdata = class_q;
      OFF_DUAL:   reg_rdata = dual_q;
      OFF_POL:    reg_rdata = pol_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [NUM_LINES-1:0] reg_wdata,
  input logic [NUM_LINES-1:0] pin_level,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] raw_stat,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] class_q,
  input logic [NUM_LINES-1:0] dual_q
);
  logic [NUM_LINES-1:0] clr_now, hit_now;
  logic [NUM_LINES-1:0] pin_d, raw_d, en_d, mask_d, class_d, clr_d, hit_d;

  assign clr_now = (reg_wr && reg_addr == OFF_CLEAR) ? reg_wdata : '0;
  // Any-edge lines that toggle while a clear hits them
  assign hit_now = clr_now & en_q & ~class_q & dual_q & (pin_level ^ pin_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d <= '0; raw_d <= '0; en_d <= '0; mask_d <= '0;
      class_d <= '0; clr_d <= '0; hit_d <= '0;
    end else begin
      pin_d <= pin_level; raw_d <= raw_stat; en_d <= en_q; mask_d <= mask_q;
      class_d <= class_q; clr_d <= clr_now; hit_d <= hit_now;
    end
  end

  logic [NUM_LINES-1:0] keep_v, fresh_v;
  assign keep_v  = ~class_q & ~class_d & raw_d & ~clr_d;
  assign fresh_v = raw_stat & ~raw_d;

  assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((keep_v & raw_stat) == keep_v));

  assert_no_raise_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((fresh_v & ~en_d & ~en_q) == '0));

  assert_irq_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out == |(raw_d & ~mask_d)));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_stat & hit_d) == hit_d));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_level(pin_level), .irq_out(irq_out),
  .raw_stat(raw_stat), .en_q(en_q), .mask_q(mask_q), .class_q(class_q),
  .dual_q(dual_q)
);

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int CLK_P = 10;
  localparam int N = 32;
  localparam logic [7:0] A_EN = 8'h20, A_RAW = 8'h24, A_MSK_ST = 8'h28,
                         A_MASK = 8'h2C, A_CLR = 8'h30, A_CLS = 8'h34,
                         A_DUAL = 8'h38, A_POL = 8'h3C;

  // {line[4:0], class, dual, pol, pin_start, pin_end, expect, spare}
  localparam int NV = 10;
  localparam logic [11:0] TBL [NV] = '{
    {5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 rising hit
    {5'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 falling ignored
    {5'd9,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 falling hit
    {5'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 rising ignored
    {5'd17, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 rise
    {5'd18, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 fall, pol 1
    {5'd23, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 high active
    {5'd24, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 high inactive
    {5'd30, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R6 low active
    {5'd31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}   // R6 low inactive
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, irq_out;
  logic [7:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0, reg_rdata, pin_level = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_detect #(.NUM_LINES(N)) u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_level(pin_level),
    .irq_out(irq_out)
  );

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_clear();
    wr(A_EN, '0); wr(A_CLS, '0); wr(A_DUAL, '0); wr(A_POL, '0); wr(A_MASK, '0);
    pin_level = '0; idle(2); wr(A_CLR, '1);
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    idle(4); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(A_EN, d);  check("R1 enable", d, '0);
    rd(A_CLS, d); check("R1 class", d, '0);
    rd(A_RAW, d); check("R1 raw", d, '0);
    check("R1 irq", {{(N-1){1'b0}}, irq_out}, '0);

    // R2 readback and write-only clear
    wr(A_POL, 32'hA5A5_0F0F); rd(A_POL, d); check("R2 pol readback", d, 32'hA5A5_0F0F);
    wr(A_MASK, 32'h1234_5678); rd(A_MASK, d); check("R2 mask readback", d, 32'h1234_5678);
    rd(A_CLR, d); check("R2 clear reads 0", d, '0);

    // Table walk: R3..R6
    for (int i = 0; i < NV; i++) begin
      logic [N-1:0] b;
      cfg_clear();
      b = 1 << TBL[i][11:7];
      wr(A_CLS, TBL[i][6] ? b : '0);
      wr(A_DUAL, TBL[i][5] ? b : '0);
      wr(A_POL, TBL[i][4] ? b : '0);
      pin_level = TBL[i][3] ? b : '0;
      wr(A_EN, b); idle(2);
      wr(A_CLR, '1);
      pin_level = TBL[i][2] ? b : '0;
      idle(2);
      rd(A_RAW, d);
      check($sformatf("R3-6 vector %0d", i), d & b, TBL[i][1] ? b : '0);
    end

    // R7 sticky, W1C with zero then one
    cfg_clear(); wr(A_EN, 32'h20);
    pin_level = 32'h20; idle(1); pin_level = '0; idle(2);
    rd(A_RAW, d); check("R7 sticky after pin idle", d, 32'h20);
    wr(A_CLR, 32'hFFFF_FFDF); rd(A_RAW, d); check("R7 write 0 keeps", d, 32'h20);
    wr(A_CLR, 32'h20); rd(A_RAW, d); check("R7 write 1 clears", d, '0);

    // R8 level not clearable
    cfg_clear(); wr(A_CLS, 32'h4); pin_level = 32'h4; wr(A_EN, 32'h4); idle(1);
    wr(A_CLR, 32'h4); rd(A_RAW, d); check("R8 level stays", d, 32'h4);

    // R9 disabled line
    cfg_clear(); wr(A_EN, 32'hFFFF_FFF7); wr(A_DUAL, '1);
    pin_level = 32'h8; idle(2); pin_level = '0; idle(2);
    rd(A_RAW, d); check("R9 disabled raw", d, '0);
    check("R9 disabled irq", {{(N-1){1'b0}}, irq_out}, '0);

    // R10 mask gating and irq
    cfg_clear(); wr(A_MASK, 32'h10); wr(A_EN, 32'h10);
    pin_level = 32'h10; idle(3);
    rd(A_RAW, d); check("R10 raw set", d, 32'h10);
    rd(A_MSK_ST, d); check("R10 masked hidden", d, '0);
    check("R10 irq low when masked", {{(N-1){1'b0}}, irq_out}, '0);
    wr(A_MASK, '0); idle(1);
    rd(A_MSK_ST, d); check("R10 masked visible", d, 32'h10);
    check("R10 irq high", {{(N-1){1'b0}}, irq_out}, 32'h1);
    wr(A_CLR, 32'h10); idle(1);
    check("R10 irq drops", {{(N-1){1'b0}}, irq_out}, '0);

    // R11 edge and clear in the same cycle
    cfg_clear(); wr(A_EN, 32'h80);
    @(negedge clk); pin_level = 32'h80; reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h80;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    rd(A_RAW, d); check("R11 event wins", d, 32'h80);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule